// File: doc/BRIEF.md
# Clock Multiplier Control Register Sequencer

This block is the control and status register of an on-chip clock multiplier, together with the small state machine that models how the multiplier is brought up. A byte-wide register bus (address, write strobe, write data, combinational read data) reaches a single register at byte address 0xBE. Software stores an enable bit and a two-bit input-source code there, then requests initialization. A read-only ready flag answers once the modelled lock time has passed.

The required bring-up order is enforced rather than merely stored. The order is: clear the register, pick a source, enable, wait, initialize. An initialize request that arrives too soon after enabling is dropped and sets a sticky sequence-error output. Changing the source or dropping the enable while running withdraws ready, and a fresh initialization is then needed. The selected source code and the effective multiplication factor leave the block as plain outputs. The analog multiplier and the clock switch are not part of it.

Top module: `clkmul_ctrl`

## Requirements
- R1: After reset the register at 0xBE reads 0x00, seq_err is 0, src_sel is 00 and mult_factor is 4.
- R2: A write to 0xBE stores bit 7 (enable) and bits 1..0 (source code). Bits 4..2 always read 0, whatever was written to them.
- R3: An initialize request (bit 6 set) written fewer than WAIT_CYC clock cycles after the write that set enable is ignored: bit 6 reads 0. The request sets seq_err.
- R4: An initialize request is accepted when enable is already 1, the write keeps enable at 1, the write leaves the source code unchanged, and at least WAIT_CYC cycles have passed since enable was set. Bit 6 then reads 1. Bit 5 (ready) reads 0 until exactly LOCK_CYC cycles after the accepting write and reads 1 from then on.
- R5: A write that sets enable and initialize together while enable was 0 enables the multiplier but does not initialize it, and it sets seq_err.
- R6: A write that changes the source code or clears enable clears bits 6 and 5. Ready stays 0 until a new initialize request is accepted, and a later accepted request brings ready back after LOCK_CYC cycles.
- R7: With source code 11 (reserved), ready never becomes 1 and mult_factor reads 0.
- R8: src_sel shows the stored source code. mult_factor is 4 for code 00, 2 for code 01 and 2 for code 10.
- R9: Writing 0x00 to 0xBE clears enable, initialize, ready, the source code and seq_err.
- R10: Writes to any other address change nothing, and reads of any other address return 0x00.
- R11: seq_err stays 1 through later accepted initializations until a 0x00 write clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| src_sel | output | 2 | Stored input-source code |
| mult_factor | output | 3 | Effective multiplication factor for the stored code |
| seq_err | output | 1 | Sticky bring-up order violation flag |

## Verification
The assertions assume a write strobe lasts one cycle per access. They also assume the bus address is stable while the strobe is high, and that reset is held for at least one clock edge before the first write. The stimulus drives every input at falling edges, pulses the write strobe for exactly one cycle per access, and places initialize requests at chosen distances from the enabling write. Those distances include the first cycle that is accepted and the cycle just before it. Reads happen with the strobe low, so a check never overlaps a register update.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;

    localparam int REG_W    = 8;
    localparam int EN_BIT   = 7;
    localparam int INIT_BIT = 6;
    localparam int RDY_BIT  = 5;

    typedef enum logic [1:0] {
        SRC_EXT_HALF = 2'b00,
        SRC_INT_HALF = 2'b01,
        SRC_EXT_FULL = 2'b10,
        SRC_RSVD     = 2'b11
    } src_e;

    typedef struct packed {
        logic hit;
        logic wipe;
        logic new_en;
        src_e new_sel;
        logic en_on;
        logic en_off;
        logic sel_chg;
        logic init_ok;
        logic init_bad;
    } wr_act_t;

    function automatic logic [2:0] factor_of(src_e s);
        case (s)
            SRC_EXT_HALF: factor_of = 3'd4;
            SRC_INT_HALF: factor_of = 3'd2;
            SRC_EXT_FULL: factor_of = 3'd2;
            default:      factor_of = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/clkmul_cycle_timer.sv
module clkmul_cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (start)
            cnt <= CW'(1);
        else if (run && cnt != LIM && cnt != '0)
            cnt <= cnt + CW'(1);
    end

    assign done = (cnt == LIM);

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIM);  // R4

    AST_TIMER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && run && !clr && !start) |=> done);  // R4
endmodule

// File: rtl/clkmul_wr_decode.sv
module clkmul_wr_decode
    import clkmul_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hBE
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              en_q,
    input  src_e              sel_q,
    input  logic              wait_done,
    output wr_act_t           act
);
    logic       init_req;
    logic [3:0] wdata_unused;

    assign wdata_unused = bus_wdata[5:2];

    always_comb begin
        act          = '0;
        act.hit      = bus_wr && (bus_addr == REG_ADDR);
        act.wipe     = act.hit && (bus_wdata == '0);
        act.new_en   = bus_wdata[EN_BIT];
        act.new_sel  = src_e'(bus_wdata[1:0]);
        act.en_on    = act.hit && !act.wipe && act.new_en && !en_q;
        act.en_off   = act.hit && en_q && !act.new_en;
        act.sel_chg  = act.hit && (act.new_sel != sel_q);
        init_req     = act.hit && !act.wipe && bus_wdata[INIT_BIT];
        act.init_ok  = init_req && en_q && act.new_en && wait_done && !act.sel_chg;
        act.init_bad = init_req && !act.init_ok;
    end
endmodule

// File: rtl/clkmul_ctrl.sv
module clkmul_ctrl
    import clkmul_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'hBE,
    parameter int                WAIT_CYC = 625,
    parameter int                LOCK_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [1:0]        src_sel,
    output logic [2:0]        mult_factor,
    output logic              seq_err
);
    logic    en_q, init_q, rdy_q, err_q;
    src_e    sel_q;
    wr_act_t act;
    logic    wait_done, lock_done, cancel;

    clkmul_wr_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .en_q     (en_q),
        .sel_q    (sel_q),
        .wait_done(wait_done),
        .act      (act)
    );

    assign cancel = act.wipe || act.en_off || act.sel_chg;

    clkmul_cycle_timer #(.LIMIT(WAIT_CYC)) u_wait (
        .clk  (clk),
        .rst  (rst),
        .clr  (act.en_off || act.wipe),
        .start(act.en_on),
        .run  (en_q),
        .done (wait_done)
    );

    clkmul_cycle_timer #(.LIMIT(LOCK_CYC)) u_lock (
        .clk  (clk),
        .rst  (rst),
        .clr  (cancel),
        .start(act.init_ok),
        .run  (init_q),
        .done (lock_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            sel_q  <= SRC_EXT_HALF;
            init_q <= 1'b0;
            rdy_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (act.hit) begin
                en_q  <= act.new_en;
                sel_q <= act.new_sel;
            end
            if (cancel)
                init_q <= 1'b0;
            else if (act.init_ok)
                init_q <= 1'b1;
            if (cancel || act.init_ok)
                rdy_q <= 1'b0;
            else if (init_q && lock_done && sel_q != SRC_RSVD)
                rdy_q <= 1'b1;
            if (act.wipe)
                err_q <= 1'b0;
            else if (act.init_bad)
                err_q <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == REG_ADDR) begin
            bus_rdata[EN_BIT]   = en_q;
            bus_rdata[INIT_BIT] = init_q;
            bus_rdata[RDY_BIT]  = rdy_q;
            bus_rdata[1:0]      = sel_q;
        end
    end

    assign src_sel     = sel_q;
    assign mult_factor = factor_of(sel_q);
    assign seq_err     = err_q;

    AST_READY_NEEDS_INIT: assert property (@(posedge clk) disable iff (rst)
        rdy_q |-> (init_q && en_q));  // R4

    AST_EARLY_INIT_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (act.hit && !act.wipe && bus_wdata[INIT_BIT] && !wait_done && !init_q)
        |=> (!init_q && err_q));  // R3

    AST_RSVD_NO_READY: assert property (@(posedge clk) disable iff (rst)
        (sel_q == SRC_RSVD) |-> !rdy_q);  // R7

    AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        act.wipe |=> (!en_q && !init_q && !rdy_q && !err_q && sel_q == SRC_EXT_HALF));  // R9

    AST_SEL_CHANGE_DROPS: assert property (@(posedge clk) disable iff (rst)
        (act.sel_chg || act.en_off) |=> (!rdy_q && !init_q));  // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !act.wipe) |=> err_q);  // R11
endmodule

// File: tb/test_clkmul_ctrl.sv
module test_clkmul_ctrl;
    localparam int WAIT = 20;
    localparam int LOCK = 12;
    localparam logic [7:0] RA = 8'hBE;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = RA;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] src_sel;
    logic [2:0] mult_factor;
    logic       seq_err;

    always #4 clk = ~clk;

    clkmul_ctrl #(.ADDR_W(8), .REG_ADDR(RA), .WAIT_CYC(WAIT), .LOCK_CYC(LOCK)) i_clkmul_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_sel(src_sel),
        .mult_factor(mult_factor), .seq_err(seq_err)
    );

    typedef struct {
        logic [7:0] rd;
        logic       err;
        logic [2:0] fac;
        logic [1:0] src;
        string      tag;
    } exp_t;

    exp_t q[$];
    event sample_ev;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;

    function automatic logic [2:0] fac_exp(logic [1:0] s);
        return (s == 2'b00) ? 3'd4 : (s == 2'b11) ? 3'd0 : 3'd2;
    endfunction

    // driver side: push an expectation for a read of address a
    task automatic expect_rd(logic [7:0] a, logic [7:0] rd, logic err, logic [1:0] src, string tag);
        exp_t e;
        bus_addr = a;
        e.rd = rd; e.err = err; e.src = src; e.fac = fac_exp(src); e.tag = tag;
        q.push_back(e);
        -> sample_ev;
        #2;
        bus_addr = RA;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = RA;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops each expectation and compares it with the outputs
    initial begin
        forever begin
            @(sample_ev);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (bus_rdata !== e.rd || seq_err !== e.err ||
                    src_sel !== e.src || mult_factor !== e.fac) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h err=%0b src=%0d fac=%0d exp rdata=%h err=%0b src=%0d fac=%0d",
                             e.tag, bus_rdata, seq_err, src_sel, mult_factor,
                             e.rd, e.err, e.src, e.fac);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        expect_rd(RA,    8'h00, 0, 2'b00, "R1 reset value");
        expect_rd(8'h00, 8'h00, 0, 2'b00, "R10 read of other address");

        wr(RA, 8'h9E);
        expect_rd(RA, 8'h82, 0, 2'b10, "R2 unused bits read zero, R8 code 10");
        wr(RA, 8'h00);
        expect_rd(RA, 8'h00, 0, 2'b00, "R9 clear write");

        wr(RA, 8'hC1);
        expect_rd(RA, 8'h81, 1, 2'b01, "R5 init with enable from disabled");
        wr(RA, 8'h00);
        expect_rd(RA, 8'h00, 0, 2'b00, "R9 clear write drops error");

        wr(RA, 8'h81);
        idle(WAIT - 3);
        wr(RA, 8'hC1);
        expect_rd(RA, 8'h81, 1, 2'b01, "R3 init one cycle early ignored");
        wr(RA, 8'hC1);
        expect_rd(RA, 8'hC1, 1, 2'b01, "R11 error kept after accepted init");
        idle(LOCK - 1);
        expect_rd(RA, 8'hC1, 1, 2'b01, "R4 not ready one cycle before lock");
        idle(1);
        expect_rd(RA, 8'hE1, 1, 2'b01, "R4 ready at lock count");

        wr(8'h55, 8'h00);
        expect_rd(RA, 8'hE1, 1, 2'b01, "R10 write to other address ignored");

        wr(RA, 8'h82);
        expect_rd(RA, 8'h82, 1, 2'b10, "R6 source change drops ready");
        idle(LOCK + 2);
        expect_rd(RA, 8'h82, 1, 2'b10, "R6 ready stays low without init");

        wr(RA, 8'h00);
        wr(RA, 8'h80);
        idle(WAIT - 2);
        wr(RA, 8'hC0);
        expect_rd(RA, 8'hC0, 0, 2'b00, "R4 init accepted at exact wait");
        idle(LOCK);
        expect_rd(RA, 8'hE0, 0, 2'b00, "R4 ready, R8 code 00 factor 4");
        wr(RA, 8'h00 | 8'h01);
        expect_rd(RA, 8'h01, 0, 2'b01, "R6 disable drops ready");

        wr(RA, 8'h00);
        wr(RA, 8'h83);
        expect_rd(RA, 8'h83, 0, 2'b11, "R7 reserved code factor 0");
        idle(WAIT);
        wr(RA, 8'hC3);
        idle(LOCK + 5);
        expect_rd(RA, 8'hC3, 0, 2'b11, "R7 reserved code never ready");

        wr(RA, 8'h00);
        wr(RA, 8'h82);
        idle(WAIT);
        wr(RA, 8'hC2);
        idle(LOCK);
        expect_rd(RA, 8'hE2, 0, 2'b10, "R4 ready on code 10");
        wr(RA, 8'h81);
        expect_rd(RA, 8'h81, 0, 2'b01, "R6 change to code 01 drops ready");
        wr(RA, 8'hC1);
        idle(LOCK);
        expect_rd(RA, 8'hE1, 0, 2'b01, "R6 fresh init restores ready");

        idle(2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule